// File: doc/BRIEF.md
# Fault Monitor with Last-Fault Snapshot

This block watches a measurement chain and its current-loop output for fault conditions and reports them as qualified, debounced flags. Each monitored quantity arrives as a digital code on a shared sample strobe: the reference level, the bridge excitation level, the measurement-side and loop-side rails, the loop current sense, a temperature code and the raw converter code. Two discrete status bits (amplifier saturation and converter clip) come with the sample as well. Every fault channel needs a run of bad samples before it raises its flag. It drops the flag either on its own, after a longer run of good samples, or only on an explicit clear strobe, depending on how that channel is configured.

When any flag rises, the block freezes one snapshot of the sample that caused it. The snapshot holds a fault code, the sample index, every monitored value and a saturating count of fault events. If the reference, the excitation or a rail is faulted, the block also raises a separate flag that marks the current readings as not trustworthy. Downstream logic reads the flags and the snapshot directly. Thresholds, run lengths and the choice of latched channels are parameters.

Top module: `fault_snapshot_monitor`

## Requirements
- R1: After reset, every fault flag, the untrusted flag, the fault count and all snapshot fields are zero.
- R2: A flag rises on the clock edge that takes the 4th consecutive bad sample of its channel. A sample that is not bad restarts the run. Cycles without sampleValid neither count toward the run nor break it.
- R3: An auto-clearing flag (flag bits 1..5) falls on the edge that takes the 16th consecutive good sample. A sample that is neither bad nor good, because it lies between the two thresholds, keeps the flag and restarts the good run.
- R4: Latched flags (bit 0 sensor, bit 6 loop) ignore good samples and fall only on an edge with clearLatched high. That clear also restarts their runs and wins over a sample in the same cycle. clearLatched has no effect on bits 1..5.
- R5: Flag bit positions and bad/good rules. Bit 1 is bad when inaSat is 1. Bit 2 is bad when adcClip is 1. Bit 3 is bad when refCode < 1800 and good when it is >= 1900. Bit 4 is bad when excCode < 1600 and good when it is >= 1700. Bit 5 is bad when either rail is < 2000 and good when both are >= 2100. Bit 6 is bad when loopCurCode < 300 or > 3800, and good when it lies within 350..3700. For bits 0..2, good means not bad.
- R6: Sensor bit 0 is bad when tempCode >= 4080 (open), when tempCode <= 15 (short), or when it differs from the previous sampled tempCode by more than 64. The first sample after reset has no previous value.
- R7: untrusted is high exactly while flag bit 3, 4 or 5 is high.
- R8: On an edge where at least one flag rises, the snapshot records the values of that sample and the sample index. The sample index is the number of earlier sampleValid cycles since reset, modulo 2^16. snapStatus is {inaSat, adcClip}. snapCount is the fault count after the event. The snapshot is not written on any other edge.
- R9: snapCode is the rising flag's bit index plus one. When several flags rise together, the lowest index wins, so the sensor fault has the highest priority.
- R10: faultCount goes up by one per snapshot event and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Marks a cycle whose input codes form a new sample |
| clearLatched | input | 1 | Drops the latched flags |
| refCode | input | 12 | Reference level code |
| excCode | input | 12 | Excitation level code |
| railMeasCode | input | 12 | Measurement rail code |
| railLoopCode | input | 12 | Loop rail code |
| loopCurCode | input | 12 | Loop current sense code |
| adcRaw | input | 24 | Raw converter code |
| tempCode | input | 12 | Temperature code |
| inaSat | input | 1 | Amplifier saturation status |
| adcClip | input | 1 | Converter clip status |
| faultFlags | output | 7 | Qualified fault flags, bit positions per R5/R6 |
| untrusted | output | 1 | Readings not trustworthy |
| faultCount | output | 8 | Saturating fault event count |
| snapCode | output | 3 | Captured fault code |
| snapTick | output | 16 | Captured sample index |
| snapRef | output | 12 | Captured reference code |
| snapExc | output | 12 | Captured excitation code |
| snapRailMeas | output | 12 | Captured measurement rail code |
| snapRailLoop | output | 12 | Captured loop rail code |
| snapLoopCur | output | 12 | Captured loop current code |
| snapAdc | output | 24 | Captured raw converter code |
| snapStatus | output | 2 | Captured {inaSat, adcClip} |
| snapCount | output | 8 | Fault count after the captured event |

## Verification
Two functions can fall in the same cycle. First, the clear strobe can arrive together with a sample that would otherwise extend or complete a run on a latched channel. Second, several channels can finish their bad runs on the same sample, and only one of them may write the snapshot. The bench provokes the first case by pulsing clearLatched together with sampleValid, both in directed steps and at random. It provokes the second by holding several fault inputs bad together so that their runs complete on one sample. A reference model written from the requirements predicts the flags, snapshot and count after every step, and the bench compares every output against it.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int NUM_FAULTS = 7;
  localparam int CODE_W     = 3;

  localparam int IDX_SENSOR = 0;
  localparam int IDX_INA    = 1;
  localparam int IDX_CLIP   = 2;
  localparam int IDX_REF    = 3;
  localparam int IDX_EXC    = 4;
  localparam int IDX_RAIL   = 5;
  localparam int IDX_LOOP   = 6;

  typedef struct packed {
    logic              capture;
    logic [CODE_W-1:0] code;
  } ctrlStrobe_t;
endpackage

// File: rtl/fm_qualifier.sv
module fm_qualifier #(
  parameter int ASSERT_CNT = 4,
  parameter int CLEAR_CNT  = 16,
  parameter bit LATCHED    = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleValid,
  input  logic clearLatched,
  input  logic isBad,
  input  logic isGood,
  output logic active,
  output logic rising
);
  localparam int MAX_RUN = (ASSERT_CNT > CLEAR_CNT) ? ASSERT_CNT : CLEAR_CNT;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  logic [RUN_W-1:0] runCnt, runNext;
  logic             activeNext;

  always_comb begin
    activeNext = active;
    runNext    = runCnt;
    if (LATCHED && clearLatched) begin
      activeNext = 1'b0;
      runNext    = '0;
    end else if (sampleValid) begin
      if (!active) begin
        if (isBad) begin
          if (runCnt == RUN_W'(ASSERT_CNT - 1)) begin
            activeNext = 1'b1;
            runNext    = '0;
          end else begin
            runNext = runCnt + 1'b1;
          end
        end else begin
          runNext = '0;
        end
      end else if (!LATCHED) begin
        if (isGood) begin
          if (runCnt == RUN_W'(CLEAR_CNT - 1)) begin
            activeNext = 1'b0;
            runNext    = '0;
          end else begin
            runNext = runCnt + 1'b1;
          end
        end else begin
          runNext = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      runCnt <= '0;
    end else begin
      active <= activeNext;
      runCnt <= runNext;
    end
  end

  assign rising = activeNext & ~active;
endmodule

// File: rtl/fm_control.sv
module fm_control
  import fm_pkg::*;
#(
  parameter int                    ASSERT_CNT = 4,
  parameter int                    CLEAR_CNT  = 16,
  parameter logic [NUM_FAULTS-1:0] LATCH_MASK = 7'b1000001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic                  clearLatched,
  input  logic [NUM_FAULTS-1:0] badVec,
  input  logic [NUM_FAULTS-1:0] goodVec,
  output logic [NUM_FAULTS-1:0] faultFlags,
  output logic                  untrusted,
  output ctrlStrobe_t           strobe
);
  logic [NUM_FAULTS-1:0] risingVec;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : gChan
    fm_qualifier #(
      .ASSERT_CNT(ASSERT_CNT),
      .CLEAR_CNT (CLEAR_CNT),
      .LATCHED   (LATCH_MASK[g])
    ) uQual (
      .clk         (clk),
      .rstN        (rstN),
      .sampleValid (sampleValid),
      .clearLatched(clearLatched),
      .isBad       (badVec[g]),
      .isGood      (goodVec[g]),
      .active      (faultFlags[g]),
      .rising      (risingVec[g])
    );
  end

  always_comb begin
    strobe.capture = |risingVec;
    strobe.code    = '0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (risingVec[i]) strobe.code = CODE_W'(i + 1);
    end
  end

  assign untrusted = faultFlags[IDX_REF] | faultFlags[IDX_EXC] | faultFlags[IDX_RAIL];
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int VAL_W        = 12,
  parameter int ADC_W        = 24,
  parameter int TEMP_W       = 12,
  parameter int CNT_W        = 8,
  parameter int TICK_W       = 16,
  parameter int REF_ASSERT   = 1800,
  parameter int REF_CLEAR    = 1900,
  parameter int EXC_ASSERT   = 1600,
  parameter int EXC_CLEAR    = 1700,
  parameter int RAIL_ASSERT  = 2000,
  parameter int RAIL_CLEAR   = 2100,
  parameter int LOOP_LO_SET  = 300,
  parameter int LOOP_LO_CLR  = 350,
  parameter int LOOP_HI_SET  = 3800,
  parameter int LOOP_HI_CLR  = 3700,
  parameter int TEMP_OPEN    = 4080,
  parameter int TEMP_SHORT   = 15,
  parameter int TEMP_RATE    = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [VAL_W-1:0]      refCode,
  input  logic [VAL_W-1:0]      excCode,
  input  logic [VAL_W-1:0]      railMeasCode,
  input  logic [VAL_W-1:0]      railLoopCode,
  input  logic [VAL_W-1:0]      loopCurCode,
  input  logic [ADC_W-1:0]      adcRaw,
  input  logic [TEMP_W-1:0]     tempCode,
  input  logic                  inaSat,
  input  logic                  adcClip,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_FAULTS-1:0] badVec,
  output logic [NUM_FAULTS-1:0] goodVec,
  output logic [CNT_W-1:0]      faultCount,
  output logic [CODE_W-1:0]     snapCode,
  output logic [TICK_W-1:0]     snapTick,
  output logic [VAL_W-1:0]      snapRef,
  output logic [VAL_W-1:0]      snapExc,
  output logic [VAL_W-1:0]      snapRailMeas,
  output logic [VAL_W-1:0]      snapRailLoop,
  output logic [VAL_W-1:0]      snapLoopCur,
  output logic [ADC_W-1:0]      snapAdc,
  output logic [1:0]            snapStatus,
  output logic [CNT_W-1:0]      snapCount
);
  logic [TEMP_W-1:0] prevTemp;
  logic              havePrev;
  logic [TICK_W-1:0] sampleTick;
  logic [CNT_W-1:0]  countNext;
  int                tempStep;
  int                refI, excI, rmI, rlI, curI, tmpI;

  always_comb begin
    refI = int'(refCode);
    excI = int'(excCode);
    rmI  = int'(railMeasCode);
    rlI  = int'(railLoopCode);
    curI = int'(loopCurCode);
    tmpI = int'(tempCode);
    tempStep = tmpI - int'(prevTemp);
    if (tempStep < 0) tempStep = -tempStep;

    badVec[IDX_SENSOR] = (tmpI >= TEMP_OPEN) || (tmpI <= TEMP_SHORT)
                         || (havePrev && (tempStep > TEMP_RATE));
    badVec[IDX_INA]    = inaSat;
    badVec[IDX_CLIP]   = adcClip;
    badVec[IDX_REF]    = refI < REF_ASSERT;
    badVec[IDX_EXC]    = excI < EXC_ASSERT;
    badVec[IDX_RAIL]   = (rmI < RAIL_ASSERT) || (rlI < RAIL_ASSERT);
    badVec[IDX_LOOP]   = (curI < LOOP_LO_SET) || (curI > LOOP_HI_SET);

    goodVec[IDX_SENSOR] = ~badVec[IDX_SENSOR];
    goodVec[IDX_INA]    = ~inaSat;
    goodVec[IDX_CLIP]   = ~adcClip;
    goodVec[IDX_REF]    = refI >= REF_CLEAR;
    goodVec[IDX_EXC]    = excI >= EXC_CLEAR;
    goodVec[IDX_RAIL]   = (rmI >= RAIL_CLEAR) && (rlI >= RAIL_CLEAR);
    goodVec[IDX_LOOP]   = (curI >= LOOP_LO_CLR) && (curI <= LOOP_HI_CLR);
  end

  assign countNext = (faultCount == '1) ? faultCount : faultCount + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTemp   <= '0;
      havePrev   <= 1'b0;
      sampleTick <= '0;
    end else if (sampleValid) begin
      prevTemp   <= tempCode;
      havePrev   <= 1'b1;
      sampleTick <= sampleTick + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCount   <= '0;
      snapCode     <= '0;
      snapTick     <= '0;
      snapRef      <= '0;
      snapExc      <= '0;
      snapRailMeas <= '0;
      snapRailLoop <= '0;
      snapLoopCur  <= '0;
      snapAdc      <= '0;
      snapStatus   <= '0;
      snapCount    <= '0;
    end else if (strobe.capture) begin
      faultCount   <= countNext;
      snapCode     <= strobe.code;
      snapTick     <= sampleTick;
      snapRef      <= refCode;
      snapExc      <= excCode;
      snapRailMeas <= railMeasCode;
      snapRailLoop <= railLoopCode;
      snapLoopCur  <= loopCurCode;
      snapAdc      <= adcRaw;
      snapStatus   <= {inaSat, adcClip};
      snapCount    <= countNext;
    end
  end
endmodule

// File: rtl/fault_snapshot_monitor.sv
module fault_snapshot_monitor
  import fm_pkg::*;
#(
  parameter int                    VAL_W      = 12,
  parameter int                    ADC_W      = 24,
  parameter int                    TEMP_W     = 12,
  parameter int                    CNT_W      = 8,
  parameter int                    TICK_W     = 16,
  parameter int                    ASSERT_CNT = 4,
  parameter int                    CLEAR_CNT  = 16,
  parameter logic [NUM_FAULTS-1:0] LATCH_MASK = 7'b1000001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic                  clearLatched,
  input  logic [VAL_W-1:0]      refCode,
  input  logic [VAL_W-1:0]      excCode,
  input  logic [VAL_W-1:0]      railMeasCode,
  input  logic [VAL_W-1:0]      railLoopCode,
  input  logic [VAL_W-1:0]      loopCurCode,
  input  logic [ADC_W-1:0]      adcRaw,
  input  logic [TEMP_W-1:0]     tempCode,
  input  logic                  inaSat,
  input  logic                  adcClip,
  output logic [NUM_FAULTS-1:0] faultFlags,
  output logic                  untrusted,
  output logic [CNT_W-1:0]      faultCount,
  output logic [CODE_W-1:0]     snapCode,
  output logic [TICK_W-1:0]     snapTick,
  output logic [VAL_W-1:0]      snapRef,
  output logic [VAL_W-1:0]      snapExc,
  output logic [VAL_W-1:0]      snapRailMeas,
  output logic [VAL_W-1:0]      snapRailLoop,
  output logic [VAL_W-1:0]      snapLoopCur,
  output logic [ADC_W-1:0]      snapAdc,
  output logic [1:0]            snapStatus,
  output logic [CNT_W-1:0]      snapCount
);
  logic [NUM_FAULTS-1:0] badVec, goodVec;
  ctrlStrobe_t           strobe;

  fm_control #(
    .ASSERT_CNT(ASSERT_CNT),
    .CLEAR_CNT (CLEAR_CNT),
    .LATCH_MASK(LATCH_MASK)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .clearLatched(clearLatched),
    .badVec      (badVec),
    .goodVec     (goodVec),
    .faultFlags  (faultFlags),
    .untrusted   (untrusted),
    .strobe      (strobe)
  );

  fm_datapath #(
    .VAL_W (VAL_W),
    .ADC_W (ADC_W),
    .TEMP_W(TEMP_W),
    .CNT_W (CNT_W),
    .TICK_W(TICK_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .refCode     (refCode),
    .excCode     (excCode),
    .railMeasCode(railMeasCode),
    .railLoopCode(railLoopCode),
    .loopCurCode (loopCurCode),
    .adcRaw      (adcRaw),
    .tempCode    (tempCode),
    .inaSat      (inaSat),
    .adcClip     (adcClip),
    .strobe      (strobe),
    .badVec      (badVec),
    .goodVec     (goodVec),
    .faultCount  (faultCount),
    .snapCode    (snapCode),
    .snapTick    (snapTick),
    .snapRef     (snapRef),
    .snapExc     (snapExc),
    .snapRailMeas(snapRailMeas),
    .snapRailLoop(snapRailLoop),
    .snapLoopCur (snapLoopCur),
    .snapAdc     (snapAdc),
    .snapStatus  (snapStatus),
    .snapCount   (snapCount)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import fm_pkg::*;
#(
  parameter int                    CNT_W      = 8,
  parameter logic [NUM_FAULTS-1:0] LATCH_MASK = 7'b1000001
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sampleValid,
  input logic                  clearLatched,
  input logic [NUM_FAULTS-1:0] faultFlags,
  input logic                  untrusted,
  input logic [CNT_W-1:0]      faultCount,
  input logic [CODE_W-1:0]     snapCode
);
  // R2: a flag can only rise on an edge that took a sample
  p_rise_needs_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((faultFlags & ~$past(faultFlags)) != '0) |-> $past(sampleValid));

  // R4: a latched flag only falls after a clear strobe
  p_latched_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((~faultFlags & $past(faultFlags) & LATCH_MASK) != '0) |-> $past(clearLatched));

  // R7: untrusted implies that at least one fault event was logged
  p_untrusted_logged_r7: assert property (@(posedge clk) disable iff (!rstN)
    untrusted |-> (faultCount != '0));

  // R8: the snapshot code only changes when some flag rises
  p_snap_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snapCode != $past(snapCode)) |-> ((faultFlags & ~$past(faultFlags)) != '0));

  // R9: once an event is logged the stored code is a valid fault code
  p_code_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount != '0) |-> (snapCode != '0));

  // R10: the count moves by at most one per edge
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount == $past(faultCount)) || (faultCount == CNT_W'($past(faultCount) + 1'b1)));

  // R10: the count sticks at its maximum
  p_count_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(faultCount) == '1) |-> (faultCount == '1));
endmodule

bind fault_snapshot_monitor fm_checker #(
  .CNT_W     (CNT_W),
  .LATCH_MASK(LATCH_MASK)
) uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .clearLatched(clearLatched),
  .faultFlags  (faultFlags),
  .untrusted   (untrusted),
  .faultCount  (faultCount),
  .snapCode    (snapCode)
);

// File: tb/tb_fault_snapshot_monitor.sv
`timescale 1ns/1ps
module tb_fault_snapshot_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic        clearLatched = 1'b0;
  logic [11:0] refCode, excCode, railMeasCode, railLoopCode, loopCurCode, tempCode;
  logic [23:0] adcRaw;
  logic        inaSat, adcClip;
  logic [6:0]  faultFlags;
  logic        untrusted;
  logic [7:0]  faultCount, snapCount;
  logic [2:0]  snapCode;
  logic [15:0] snapTick;
  logic [11:0] snapRef, snapExc, snapRailMeas, snapRailLoop, snapLoopCur;
  logic [23:0] snapAdc;
  logic [1:0]  snapStatus;

  always #10 clk = ~clk;

  fault_snapshot_monitor dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .clearLatched(clearLatched),
    .refCode(refCode), .excCode(excCode), .railMeasCode(railMeasCode),
    .railLoopCode(railLoopCode), .loopCurCode(loopCurCode), .adcRaw(adcRaw),
    .tempCode(tempCode), .inaSat(inaSat), .adcClip(adcClip),
    .faultFlags(faultFlags), .untrusted(untrusted), .faultCount(faultCount),
    .snapCode(snapCode), .snapTick(snapTick), .snapRef(snapRef), .snapExc(snapExc),
    .snapRailMeas(snapRailMeas), .snapRailLoop(snapRailLoop), .snapLoopCur(snapLoopCur),
    .snapAdc(snapAdc), .snapStatus(snapStatus), .snapCount(snapCount)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state, built from the requirements
  localparam bit [6:0] LATCHED_M = 7'b1000001;
  bit [6:0]  eFlags = '0;
  int        runCnt [7];
  int        eCount = 0, eCode = 0, eTick = 0, eSnapCnt = 0, tickCtr = 0;
  int        eRef = 0, eExc = 0, eRm = 0, eRl = 0, eCur = 0, eAdc = 0, eStat = 0;
  int        prevTmp = 0;
  bit        havePrev = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit badOf(int i);
    int d;
    d = int'(tempCode) - prevTmp;
    if (d < 0) d = -d;
    case (i)
      0: return (tempCode >= 4080) || (tempCode <= 15) || (havePrev && d > 64);
      1: return inaSat;
      2: return adcClip;
      3: return refCode < 1800;
      4: return excCode < 1600;
      5: return (railMeasCode < 2000) || (railLoopCode < 2000);
      default: return (loopCurCode < 300) || (loopCurCode > 3800);
    endcase
  endfunction

  function automatic bit goodOf(int i);
    case (i)
      0, 1, 2: return !badOf(i);
      3: return refCode >= 1900;
      4: return excCode >= 1700;
      5: return (railMeasCode >= 2100) && (railLoopCode >= 2100);
      default: return (loopCurCode >= 350) && (loopCurCode <= 3700);
    endcase
  endfunction

  task automatic modelStep(bit s, bit c);
    bit [6:0] newM = '0;
    bit [6:0] bad, good;
    int code = 0;
    for (int i = 0; i < 7; i++) begin
      bad[i] = badOf(i);
      good[i] = goodOf(i);
    end
    for (int i = 0; i < 7; i++) begin
      bit was = eFlags[i];
      if (LATCHED_M[i] && c) begin
        eFlags[i] = 1'b0; runCnt[i] = 0;
      end else if (s) begin
        if (!eFlags[i]) begin
          if (bad[i]) begin
            if (runCnt[i] == 3) begin eFlags[i] = 1'b1; runCnt[i] = 0; end
            else runCnt[i]++;
          end else runCnt[i] = 0;
        end else if (!LATCHED_M[i]) begin
          if (good[i]) begin
            if (runCnt[i] == 15) begin eFlags[i] = 1'b0; runCnt[i] = 0; end
            else runCnt[i]++;
          end else runCnt[i] = 0;
        end
      end
      newM[i] = eFlags[i] && !was;
    end
    for (int i = 6; i >= 0; i--) if (newM[i]) code = i + 1;
    if (code != 0) begin
      if (eCount < 255) eCount++;
      eCode = code; eTick = tickCtr; eSnapCnt = eCount;
      eRef = refCode; eExc = excCode; eRm = railMeasCode; eRl = railLoopCode;
      eCur = loopCurCode; eAdc = adcRaw; eStat = {inaSat, adcClip};
    end
    if (s) begin
      tickCtr = (tickCtr + 1) & 16'hFFFF;
      prevTmp = tempCode;
      havePrev = 1'b1;
    end
  endtask

  task automatic compareAll();
    chk("R2 faultFlags", faultFlags, eFlags);
    chk("R7 untrusted", untrusted, eFlags[3] | eFlags[4] | eFlags[5]);
    chk("R10 faultCount", faultCount, eCount);
    chk("R9 snapCode", snapCode, eCode);
    chk("R8 snapTick", snapTick, eTick);
    chk("R8 snapValues", {snapRef, snapExc, snapRailMeas, snapRailLoop, snapLoopCur},
        {12'(eRef), 12'(eExc), 12'(eRm), 12'(eRl), 12'(eCur)});
    chk("R8 snapAdc", snapAdc, eAdc);
    chk("R8 snapStatus", snapStatus, eStat);
    chk("R8 snapCount", snapCount, eSnapCnt);
  endtask

  task automatic step(bit s, bit c);
    @(negedge clk);
    sampleValid = s;
    clearLatched = c;
    modelStep(s, c);
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    clearLatched = 1'b0;
    compareAll();
  endtask

  task automatic nominal();
    refCode = 2000; excCode = 1800; railMeasCode = 2500; railLoopCode = 2500;
    loopCurCode = 2000; tempCode = 12'(prevTmp); inaSat = 0; adcClip = 0;
    adcRaw = 24'($urandom);
  endtask

  function automatic logic [11:0] nearBand(int setT, int clrT);
    return 12'(setT - 40 + int'($urandom % 32'(clrT - setT + 80)));
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 7; i++) runCnt[i] = 0;
    prevTmp = 1000;
    nominal();
    prevTmp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    compareAll();
    chk("R1 flags after reset", faultFlags, 0);
    chk("R1 count after reset", faultCount, 0);
    chk("R1 snapshot after reset", {snapCode, snapTick, snapAdc, snapCount}, 0);

    prevTmp = 1000; nominal(); prevTmp = 0;
    step(1, 0);  // first sample, temperature 1000 without a previous value

    // R2: run of three, broken, then four with idle gaps in between
    refCode = 1700;
    repeat (3) step(1, 0);
    refCode = 2000; step(1, 0);
    refCode = 1700;
    repeat (3) step(1, 0);
    chk("R2 three bad samples keep flag low", faultFlags[3], 0);
    repeat (5) step(0, 0);
    step(1, 0);
    chk("R2 fourth bad sample raises ref flag", faultFlags[3], 1);
    chk("R7 untrusted follows ref flag", untrusted, 1);
    chk("R8 snapshot ref value", snapRef, 1700);

    // R3: value between thresholds holds the flag, then 16 good clear it
    refCode = 1850;
    repeat (20) step(1, 0);
    chk("R3 in-band samples keep flag", faultFlags[3], 1);
    refCode = 1900;
    repeat (15) step(1, 0);
    chk("R3 fifteen good samples keep flag", faultFlags[3], 1);
    step(1, 0);
    chk("R3 sixteenth good sample clears flag", faultFlags[3], 0);

    // R4 and R5: loop open latches; clear strobe ignored by auto channels
    loopCurCode = 100; inaSat = 1;
    repeat (4) step(1, 0);
    chk("R5 loop low current flags bit 6", faultFlags[6], 1);
    loopCurCode = 2000;
    repeat (20) step(1, 0);
    chk("R4 latched loop flag ignores good samples", faultFlags[6], 1);
    step(0, 1);
    chk("R4 clear drops latched loop flag", faultFlags[6], 0);
    chk("R4 clear leaves auto ina flag", faultFlags[1], 1);
    inaSat = 0;
    repeat (16) step(1, 0);
    loopCurCode = 3900;
    repeat (3) step(1, 0);
    step(1, 1);
    chk("R4 clear wins over coincident sample", faultFlags[6], 0);
    repeat (3) step(1, 0);
    chk("R4 run restarted after clear", faultFlags[6], 0);
    step(1, 0);
    chk("R5 loop high current flags bit 6", faultFlags[6], 1);
    loopCurCode = 2000; step(0, 1);

    // R6: open code, then excessive rate of change
    tempCode = 4080;
    repeat (4) step(1, 0);
    chk("R6 open temperature code", faultFlags[0], 1);
    tempCode = 1000; step(1, 1);
    for (int k = 0; k < 4; k++) begin
      tempCode = (k % 2) ? 12'd1000 : 12'd1065;
      step(1, 0);
    end
    chk("R6 rate of change over 64", faultFlags[0], 1);
    tempCode = 1000; step(0, 1);
    for (int k = 0; k < 6; k++) begin
      tempCode = (k % 2) ? 12'd1000 : 12'd1064;
      step(1, 0);
    end
    chk("R6 rate of exactly 64 accepted", faultFlags[0], 0);
    tempCode = 1000;

    // R9: simultaneous faults resolve by priority
    inaSat = 1; adcClip = 1; excCode = 1500; tempCode = 10;
    repeat (4) step(1, 0);
    chk("R9 sensor wins simultaneous rise", snapCode, 1);
    chk("R8 snapStatus both bits", snapStatus, 3);
    inaSat = 0; adcClip = 0; excCode = 1800; tempCode = 1000;
    repeat (16) step(1, 0);
    step(0, 1);
    inaSat = 1; adcClip = 1; railLoopCode = 1900;
    repeat (4) step(1, 0);
    chk("R9 ina wins over clip and rail", snapCode, 2);
    inaSat = 0; adcClip = 0; railLoopCode = 2500;
    repeat (16) step(1, 0);

    // random mix near thresholds with occasional clears
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      if (r < 8) begin
        nominal();
      end else if (r < 50) begin
        case ($urandom % 8)
          0: refCode = nearBand(1800, 1900);
          1: excCode = nearBand(1600, 1700);
          2: railMeasCode = nearBand(2000, 2100);
          3: railLoopCode = nearBand(2000, 2100);
          4: loopCurCode = ($urandom % 2) ? nearBand(300, 350) : 12'(3700 - 40 + int'($urandom % 180));
          5: tempCode = 12'(int'(tempCode) + int'($urandom % 141) - 70);
          6: inaSat = $urandom % 2;
          default: adcClip = $urandom % 2;
        endcase
      end
      adcRaw = 24'($urandom);
      step(($urandom % 8) != 0, ($urandom % 30) == 0);
    end
    nominal();
    step(0, 1);
    repeat (16) step(1, 0);

    // R10: saturation of the event count
    for (int k = 0; k < 260; k++) begin
      inaSat = 1; repeat (4) step(1, 0);
      inaSat = 0; repeat (16) step(1, 0);
    end
    chk("R10 count saturates at 255", faultCount, 255);
    chk("R10 snapCount saturates at 255", snapCount, 255);

    done = 1'b1;
    summary();
  end
endmodule